// File: doc/BRIEF.md
# Interrupt Event Latch and Mask Unit

This unit gathers three events from a serial peripheral controller and turns them into one level-sensitive interrupt. A completed frame-count sequence sets two sticky raw bits, transfer done and receive ready. A dropped receive frame sets a third sticky raw bit, receive overflow. Each raw bit stays set until software clears it.

Three enable bits in the controller's control word gate the raw bits into a masked status. These enable bits sit at different positions in the control word than the raw bits they gate, so the unit moves each enable onto its raw bit before masking. The interrupt line is high whenever any masked bit is set. The masked value and the interrupt follow the current raw bits and enables combinationally, so an enable that is switched on over a pending bit raises the line in the same cycle.

Software clears raw bits one at a time through a write-one-to-clear register. Bus writes aimed at the raw, masked or status registers have no effect. The bus decoder in front of the unit reduces each write to a select code and a data word.

Top module: `irq_status_unit`

## Requirements
- R1: A one-cycle `seq_done` pulse sets raw bit 0 (transfer done) and raw bit 1 (receive ready) at the next rising clock edge.
- R2: A one-cycle `frame_drop` pulse sets raw bit 2 (receive overflow) at the next rising clock edge.
- R3: Control word bit 5 enables raw bit 0, bit 4 enables raw bit 1 and bit 6 enables raw bit 2. No other control bit affects the masked status.
- R4: `masked_status` equals the raw bits ANDed with the remapped enables. It follows a change of `ctrl_word` in the same cycle, with no clock edge between.
- R5: `irq` is high exactly when at least one bit of `masked_status` is set.
- R6: A write with `wr_sel` = 0 (the clear register) clears each raw bit whose matching `wr_data` bit (0, 1 or 2) is 1. The change takes effect at the next rising edge.
- R7: Zero bits in a clear write leave the matching raw bits unchanged. Set raw bits stay set when no clear write arrives.
- R8: Writes with `wr_sel` = 1 (raw), 2 (masked) or 3 (status) leave every raw bit unchanged, whatever the data.
- R9: When an event and a clear of the same raw bit arrive in the same cycle, the bit ends up set.
- R10: While `rst_n` is low, every raw bit is zero, so `masked_status` and `irq` are zero whatever the events and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_done | input | 1 | Pulse: a frame-count sequence has completed |
| frame_drop | input | 1 | Pulse: a received frame was discarded |
| ctrl_word | input | CTRL_W | Current control register value; the enables are taken from bits 4 to 6 |
| wr_valid | input | 1 | A bus write is present this cycle |
| wr_sel | input | SEL_W | Write target: 0 clear, 1 raw, 2 masked, 3 status |
| wr_data | input | DATA_W | Write data; bits 0 to 2 are used by the clear register |
| raw_status | output | 3 | Raw sticky event bits: 0 done, 1 receive ready, 2 overflow |
| masked_status | output | 3 | Raw bits gated by the remapped enables |
| irq | output | 1 | Level interrupt request |

## Verification
A lost or wrong raw bit appears on `raw_status` one edge after the event or write that caused it. Through the mask it also appears on `masked_status` and `irq` as soon as the matching enable is on. Because the mask is combinational, a wrong enable mapping shows up in the same cycle the control word changes, before any clock edge. The bench therefore checks the mask outputs right after it drives new inputs and checks the raw bits after each edge. A clear or ignored write that disturbs the wrong bit is caught on the very next cycle. The same-cycle event-and-clear collision is also seen on the next cycle.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int CTRL_W       = 32,
  parameter int DATA_W       = 32,
  parameter int SEL_W        = 2,
  parameter int EN_DONE_POS  = 5,
  parameter int EN_RXRDY_POS = 4,
  parameter int EN_OVF_POS   = 6,
  parameter int SEL_CLEAR    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_done,
  input  logic              frame_drop,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              wr_valid,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [2:0]        raw_status,
  output logic [2:0]        masked_status,
  output logic              irq
);

  localparam logic [SEL_W-1:0] SEL_CLR_CODE = SEL_W'(SEL_CLEAR);

  logic [2:0] raw_q;
  logic [2:0] set_vec;
  logic [2:0] clr_vec;
  logic [2:0] en_vec;
  logic       clr_hit;

  assign set_vec = {frame_drop, seq_done, seq_done};
  assign clr_hit = wr_valid && (wr_sel == SEL_CLR_CODE);
  assign clr_vec = clr_hit ? wr_data[2:0] : 3'b000;

  assign en_vec = {ctrl_word[EN_OVF_POS], ctrl_word[EN_RXRDY_POS], ctrl_word[EN_DONE_POS]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 3'b000;
    else        raw_q <= (raw_q & ~clr_vec) | set_vec;
  end

  assign raw_status    = raw_q;
  assign masked_status = raw_q & en_vec;
  assign irq           = |masked_status;

  logic unused_bits;
  assign unused_bits = ^{ctrl_word, wr_data};

endmodule

module irq_status_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       seq_done,
  input logic       frame_drop,
  input logic       wr_valid,
  input logic [1:0] wr_sel,
  input logic [2:0] wr_low,
  input logic [2:0] raw_status,
  input logic [2:0] masked_status,
  input logic       irq
);

  logic clr_w;
  assign clr_w = wr_valid && (wr_sel == 2'd0);

  p_done_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (raw_status[1:0] == 2'b11));

  p_drop_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |=> raw_status[2]);

  p_mask_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_status & ~raw_status) == 3'b000);

  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_status == 3'b000) |-> !irq);

  p_irq_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_status != 3'b000) |-> irq);

  p_clear_bit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && wr_low[0] && !seq_done) |=> !raw_status[0]);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_done && !frame_drop && !clr_w) |=> $stable(raw_status));

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel != 2'd0 && !seq_done && !frame_drop) |=> $stable(raw_status));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && wr_low[2] && frame_drop) |=> raw_status[2]);

  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (raw_status == 3'b000 || $past(rst_n)));

endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .frame_drop(frame_drop),
  .wr_valid(wr_valid), .wr_sel(wr_sel[1:0]), .wr_low(wr_data[2:0]),
  .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seq_done = 1'b0;
  logic        frame_drop = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  raw_status;
  logic [2:0]  masked_status;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [2:0] raw_m = 3'b000;

  always #5 clk = ~clk;

  irq_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .frame_drop(frame_drop),
    .ctrl_word(ctrl_word), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
    .raw_status(raw_status), .masked_status(masked_status), .irq(irq)
  );

  function automatic logic [2:0] en_of(input logic [31:0] c);
    return {c[6], c[4], c[5]};
  endfunction

  function automatic logic [2:0] next_raw(input logic [2:0] r, input logic sd,
      input logic fd, input logic wv, input logic [1:0] sel, input logic [31:0] d);
    logic [2:0] clr;
    clr = (wv && sel == 2'd0) ? d[2:0] : 3'b000;
    return (r & ~clr) | {fd, sd, sd};
  endfunction

  task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_mask(input string tag);
    check3({tag, " R4 masked"}, masked_status, raw_m & en_of(ctrl_word));
    check3({tag, " R5 irq"}, {2'b00, irq}, {2'b00, |(raw_m & en_of(ctrl_word))});
  endtask

  // Called at a negedge: drive, check mask at once, clock, check raw.
  task automatic cycle(input string tag, input logic sd, input logic fd,
      input logic wv, input logic [1:0] sel, input logic [31:0] d, input logic [31:0] c);
    seq_done = sd; frame_drop = fd; wr_valid = wv; wr_sel = sel; wr_data = d; ctrl_word = c;
    #1;
    check_mask(tag);
    @(posedge clk);
    raw_m = next_raw(raw_m, sd, fd, wv, sel, d);
    @(negedge clk);
    seq_done = 1'b0; frame_drop = 1'b0; wr_valid = 1'b0;
    check3({tag, " raw"}, raw_status, raw_m);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    ctrl_word = 32'hFFFF_FFFF;
    seq_done = 1'b1; frame_drop = 1'b1;
    repeat (3) @(negedge clk);
    check3("R10 raw in reset", raw_status, 3'b000);
    check3("R10 masked in reset", masked_status, 3'b000);
    check3("R10 irq in reset", {2'b00, irq}, 3'b000);
    seq_done = 1'b0; frame_drop = 1'b0; ctrl_word = '0;
    rst_n = 1'b1;
    @(negedge clk);

    cycle("R1 seq_done", 1, 0, 0, 0, 0, 32'h0);
    check3("R1 bits 0,1 set", raw_status, 3'b011);
    cycle("R2 frame_drop", 0, 1, 0, 0, 0, 32'h0);
    check3("R2 bit 2 set", raw_status, 3'b111);
    cycle("R7 clear with zeros", 0, 0, 1, 2'd0, 32'hFFFF_FFF8, 32'h0);
    check3("R7 raw kept", raw_status, 3'b111);
    cycle("R8 write raw", 0, 0, 1, 2'd1, 32'hFFFF_FFFF, 32'h0);
    cycle("R8 write masked", 0, 0, 1, 2'd2, 32'hFFFF_FFFF, 32'h0);
    cycle("R8 write status", 0, 0, 1, 2'd3, 32'hFFFF_FFFF, 32'h0);
    check3("R8 raw kept", raw_status, 3'b111);
    ctrl_word = 32'h0000_0020; #1;
    check3("R3 bit5 -> done", masked_status, 3'b001);
    check3("R4 irq same cycle", {2'b00, irq}, 3'b001);
    ctrl_word = 32'h0000_0010; #1;
    check3("R3 bit4 -> rxrdy", masked_status, 3'b010);
    ctrl_word = 32'h0000_0040; #1;
    check3("R3 bit6 -> ovf", masked_status, 3'b100);
    ctrl_word = 32'hFFFF_FF8F; #1;
    check3("R3 other bits no effect", masked_status, 3'b000);
    check3("R5 irq low", {2'b00, irq}, 3'b000);
    @(negedge clk);
    cycle("R6 clear bit1", 0, 0, 1, 2'd0, 32'h2, 32'h70);
    check3("R6 only bit1 cleared", raw_status, 3'b101);
    cycle("R9 drop vs clear", 0, 1, 1, 2'd0, 32'h4, 32'h70);
    check3("R9 event wins", raw_status, 3'b101);
    cycle("R9 done vs clear", 1, 0, 1, 2'd0, 32'h3, 32'h70);
    check3("R9 event wins 0,1", raw_status, 3'b111);
    cycle("R6 clear all", 0, 0, 1, 2'd0, 32'h7, 32'h70);
    check3("R6 all cleared", raw_status, 3'b000);
    check3("R5 irq after clear", {2'b00, irq}, 3'b000);

    for (int i = 0; i < 600; i++) begin
      logic sd, fd, wv;
      logic [1:0] sel;
      logic [31:0] d, c;
      sd  = ($urandom % 5) == 0;
      fd  = ($urandom % 6) == 0;
      wv  = ($urandom % 3) == 0;
      sel = 2'($urandom % 4);
      d   = $urandom;
      c   = $urandom;
      cycle("R1 R2 R6 R7 R8 R9 random", sd, fd, wv, sel, d, c);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule